// File: doc/BRIEF.md
# Stack FPU Subtract Decoder

This block decodes the subtract group of a stack-organised floating-point unit. It takes two bytes, the primary opcode and the ModRM byte, and reports the result in the same cycle. The outputs say whether the pair is a subtract and what kind of source it uses: a stack register, or a 32-bit float, 64-bit float, 16-bit integer or 32-bit integer in memory. They also give the destination stack index, the source stack index, whether the stack top acts as the subtrahend rather than the minuend, whether the stack is popped afterwards, and whether an integer source must first be widened to the extended format.

The issue stage uses it to route operands to the subtractor and to schedule the pop. It does not compute addresses, touch memory or do the arithmetic. Any pair outside the group raises `not_family`, and all the other outputs are then zero.

Top module: `fpu_sub_decoder`

## Requirements
- R1: Only the encodings listed in R2 to R9 set `is_sub`=1 and `not_family`=0. Every other pair sets `is_sub`=0 and `not_family`=1 and drives `src_kind`, `dst_idx`, `src_idx`, `reversed`, `pop_after` and `int_convert` to 0.
- R2: Primary 0xD8 with a memory ModRM (mod not 2'b11) and reg field 3'd4 gives `src_kind`=2 (32-bit float). It also gives `dst_idx`=0, `src_idx`=0, `reversed`=0, `pop_after`=0 and `int_convert`=0.
- R3: Primary 0xDC with a memory ModRM and reg field 4 gives `src_kind`=3 (64-bit float). The other outputs are as in R2.
- R4: Primary 0xDA with a memory ModRM and reg field 4 gives `src_kind`=5 (32-bit integer) and `int_convert`=1. `dst_idx`=0, `src_idx`=0, `reversed`=0 and `pop_after`=0.
- R5: Primary 0xDE with a memory ModRM and reg field 4 gives `src_kind`=4 (16-bit integer) and `int_convert`=1. The other outputs are as in R4.
- R6: Primary 0xD8 with second byte 0xE0+i gives `src_kind`=1 (register), `dst_idx`=0, `src_idx`=i, `reversed`=0 and `pop_after`=0. The operation is ST(0) minus ST(i).
- R7: Primary 0xDC with second byte 0xE8+i gives `src_kind`=1, `dst_idx`=i, `src_idx`=0, `reversed`=1 and `pop_after`=0. The operation is ST(i) minus ST(0).
- R8: Primary 0xDE with second byte 0xE8+i gives the same outputs as R7 except `pop_after`=1.
- R9: The pair 0xDE 0xE9, the form with no operand, gives `dst_idx`=1, `src_idx`=0, `reversed`=1 and `pop_after`=1.
- R10: The memory forms ignore ModRM bits [2:0], which only select addressing. Any mod value other than 2'b11 selects the memory form.
- R11: Register forms with the wrong reg field are not subtracts. These are 0xD8 0xE8+i, 0xDC 0xE0+i and 0xDE 0xE0+i. 0xDA with mod 2'b11 is not a subtract either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_byte | input | 8 | Primary opcode byte |
| modrm_byte | input | 8 | ModRM byte (mod [7:6], reg [5:3], rm [2:0]) |
| is_sub | output | 1 | Pair belongs to the subtract group |
| not_family | output | 1 | Pair is outside the group |
| src_kind | output | 3 | 0 none, 1 register, 2 f32, 3 f64, 4 i16, 5 i32 |
| dst_idx | output | 3 | Stack index written with the result |
| src_idx | output | 3 | Stack index of the subtrahend |
| reversed | output | 1 | Minuend is ST(i) and ST(0) is subtracted from it |
| pop_after | output | 1 | Stack is popped after the subtract |
| int_convert | output | 1 | Source is an integer and is widened first |

## Verification
The bench first aims at the near misses. These are the register encodings one reg value away from a subtract (0xD8 0xE8+i and 0xDC 0xE0+i), which a decoder ignoring the reg field would accept as subtracts with the wrong direction. It also tries 0xDA with mod 2'b11, which a decoder keying only on reg would wrongly take as an integer load. Memory forms are driven with every mod and rm value, so a decoder that tests a single mod bit, or lets rm leak into the stack index, shows up as a wrong `src_kind` or a nonzero index. The sweep over all 65536 byte pairs also checks that the pop appears only for 0xDE register forms, including 0xDE 0xE9, and that the direction flag is set only for the forms whose destination is ST(i).

// File: rtl/fsub_dec_pkg.sv
package fsub_dec_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned KIND_W = 3;

  localparam logic [BYTE_W-1:0] OPC_GRP_A = 8'hD8;  // f32 mem / reg forward
  localparam logic [BYTE_W-1:0] OPC_GRP_B = 8'hDA;  // i32 mem
  localparam logic [BYTE_W-1:0] OPC_GRP_C = 8'hDC;  // f64 mem / reg reverse
  localparam logic [BYTE_W-1:0] OPC_GRP_D = 8'hDE;  // i16 mem / reg reverse + pop

  localparam logic [2:0] REG_FWD = 3'd4;
  localparam logic [2:0] REG_REV = 3'd5;
  localparam logic [1:0] MOD_REG = 2'b11;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE = 3'd0,
    KIND_STK  = 3'd1,
    KIND_F32  = 3'd2,
    KIND_F64  = 3'd3,
    KIND_I16  = 3'd4,
    KIND_I32  = 3'd5
  } src_kind_e;

  typedef struct packed {
    logic             hit;
    src_kind_e        kind;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src;
    logic             rev;
    logic             pop;
    logic             cvt;
  } dec_res_t;

endpackage

// File: rtl/fsub_modrm_split.sv
module fsub_modrm_split
  import fsub_dec_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0]     modrm,
  output logic             reg_form,
  output logic [2:0]       reg_f,
  output logic [IDX_W-1:0] rm_f
);
  localparam int unsigned MOD_HI = W - 1;
  localparam int unsigned MOD_LO = W - 2;

  always_comb begin
    reg_form = (modrm[MOD_HI:MOD_LO] == MOD_REG);
    reg_f    = modrm[5:3];
    rm_f     = modrm[IDX_W-1:0];
  end
endmodule

// File: rtl/fsub_mem_decode.sv
module fsub_mem_decode
  import fsub_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic              reg_form,
  input  logic [2:0]        reg_f,
  output dec_res_t          res
);
  always_comb begin
    res      = '0;
    res.kind = KIND_NONE;
    if (!reg_form && reg_f == REG_FWD) begin
      unique case (op)
        OPC_GRP_A: begin res.hit = 1'b1; res.kind = KIND_F32; end
        OPC_GRP_C: begin res.hit = 1'b1; res.kind = KIND_F64; end
        OPC_GRP_B: begin res.hit = 1'b1; res.kind = KIND_I32; res.cvt = 1'b1; end
        OPC_GRP_D: begin res.hit = 1'b1; res.kind = KIND_I16; res.cvt = 1'b1; end
        default:   res = '0;
      endcase
    end
  end
endmodule

// File: rtl/fsub_reg_decode.sv
module fsub_reg_decode
  import fsub_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  input  logic              reg_form,
  input  logic [2:0]        reg_f,
  input  logic [IDX_W-1:0]  rm_f,
  output dec_res_t          res
);
  logic fwd_hit;
  logic rev_hit;
  logic rev_pop;

  always_comb begin
    fwd_hit = reg_form && (op == OPC_GRP_A) && (reg_f == REG_FWD);
    rev_pop = reg_form && (op == OPC_GRP_D) && (reg_f == REG_REV);
    rev_hit = rev_pop || (reg_form && (op == OPC_GRP_C) && (reg_f == REG_REV));
  end

  always_comb begin
    res      = '0;
    res.kind = KIND_NONE;
    if (fwd_hit) begin
      res.hit  = 1'b1;
      res.kind = KIND_STK;
      res.src  = rm_f;
    end else if (rev_hit) begin
      res.hit  = 1'b1;
      res.kind = KIND_STK;
      res.dst  = rm_f;
      res.rev  = 1'b1;
      res.pop  = rev_pop;
    end
  end
endmodule

// File: rtl/fpu_sub_decoder.sv
module fpu_sub_decoder
  import fsub_dec_pkg::*;
(
  input  logic [7:0] op_byte,
  input  logic [7:0] modrm_byte,
  output logic       is_sub,
  output logic       not_family,
  output logic [2:0] src_kind,
  output logic [2:0] dst_idx,
  output logic [2:0] src_idx,
  output logic       reversed,
  output logic       pop_after,
  output logic       int_convert
);
  logic             reg_form;
  logic [2:0]       reg_f;
  logic [IDX_W-1:0] rm_f;
  dec_res_t         mem_res;
  dec_res_t         reg_res;
  dec_res_t         sel;

  fsub_modrm_split #(.W(BYTE_W)) u_split (
    .modrm    (modrm_byte),
    .reg_form (reg_form),
    .reg_f    (reg_f),
    .rm_f     (rm_f)
  );

  fsub_mem_decode u_mem (
    .op       (op_byte),
    .reg_form (reg_form),
    .reg_f    (reg_f),
    .res      (mem_res)
  );

  fsub_reg_decode u_reg (
    .op       (op_byte),
    .reg_form (reg_form),
    .reg_f    (reg_f),
    .rm_f     (rm_f),
    .res      (reg_res)
  );

  always_comb begin
    if (mem_res.hit)      sel = mem_res;
    else if (reg_res.hit) sel = reg_res;
    else                  sel = '0;
  end

  always_comb begin
    is_sub      = sel.hit;
    not_family  = !sel.hit;
    src_kind    = sel.kind;
    dst_idx     = sel.dst;
    src_idx     = sel.src;
    reversed    = sel.rev;
    pop_after   = sel.pop;
    int_convert = sel.cvt;
  end
endmodule

// File: rtl/fpu_sub_decoder_chk.sv
module fpu_sub_decoder_chk (
  input logic [7:0] op_byte,
  input logic [7:0] modrm_byte,
  input logic       is_sub,
  input logic       not_family,
  input logic [2:0] src_kind,
  input logic [2:0] dst_idx,
  input logic [2:0] src_idx,
  input logic       reversed,
  input logic       pop_after,
  input logic       int_convert
);
  always_comb begin
    // R1: exactly one of the two classification outputs
    a_r1_one_class: assert (is_sub ^ not_family);
    // R1: a miss drives every field to zero
    if (not_family)
      a_r1_quiet_miss: assert ({src_kind, dst_idx, src_idx, reversed, pop_after, int_convert} == '0);
    // R10: memory forms never carry stack indices or pop
    if (is_sub && src_kind >= 3'd2)
      a_r10_mem_no_index: assert (dst_idx == 3'd0 && src_idx == 3'd0 && !reversed && !pop_after);
    // R8: pop only for primary 0xDE register form
    if (pop_after)
      a_r8_pop_only_de: assert (op_byte == 8'hDE && modrm_byte[7:6] == 2'b11 && reversed);
    // R7: reversed forms write ST(i) and read ST(0)
    if (reversed)
      a_r7_rev_indices: assert (dst_idx == modrm_byte[2:0] && src_idx == 3'd0);
    // R4: conversion only for integer sources
    if (int_convert)
      a_r4_cvt_integer: assert (op_byte == 8'hDA || op_byte == 8'hDE);
  end
endmodule

bind fpu_sub_decoder fpu_sub_decoder_chk u_chk (
  .op_byte     (op_byte),
  .modrm_byte  (modrm_byte),
  .is_sub      (is_sub),
  .not_family  (not_family),
  .src_kind    (src_kind),
  .dst_idx     (dst_idx),
  .src_idx     (src_idx),
  .reversed    (reversed),
  .pop_after   (pop_after),
  .int_convert (int_convert)
);

// File: tb/fpu_sub_decoder_tb_top.sv
module fpu_sub_decoder_tb_top;
  logic clk;
  logic rst_n;
  logic [7:0] op_byte;
  logic [7:0] modrm_byte;
  logic is_sub, not_family, reversed, pop_after, int_convert;
  logic [2:0] src_kind, dst_idx, src_idx;

  int n_run;
  int n_fail;
  bit finished;

  typedef struct {
    logic [13:0] exp;
    string       tag;
    logic [7:0]  op;
    logic [7:0]  mr;
  } item_t;

  item_t sb_q[$];

  fpu_sub_decoder dut_i (
    .op_byte(op_byte), .modrm_byte(modrm_byte),
    .is_sub(is_sub), .not_family(not_family), .src_kind(src_kind),
    .dst_idx(dst_idx), .src_idx(src_idx), .reversed(reversed),
    .pop_after(pop_after), .int_convert(int_convert)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // pack: {is_sub, not_family, kind[3], dst[3], src[3], rev, pop, cvt}
  function automatic logic [13:0] pack(input logic h, input logic [2:0] k,
    input logic [2:0] d, input logic [2:0] s, input logic r, input logic p, input logic c);
    return {h, !h, k, d, s, r, p, c};
  endfunction

  function automatic item_t model(input logic [7:0] op, input logic [7:0] mr);
    item_t it;
    logic [1:0] md = mr[7:6];
    logic [2:0] rg = mr[5:3];
    logic [2:0] i  = mr[2:0];
    it.op = op; it.mr = mr;
    it.exp = pack(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0);
    it.tag = "R1/R11";
    if (md != 2'b11 && rg == 3'd4) begin
      if (op == 8'hD8) begin it.exp = pack(1, 3'd2, 0, 0, 0, 0, 0); it.tag = "R2/R10"; end
      if (op == 8'hDC) begin it.exp = pack(1, 3'd3, 0, 0, 0, 0, 0); it.tag = "R3/R10"; end
      if (op == 8'hDA) begin it.exp = pack(1, 3'd5, 0, 0, 0, 0, 1); it.tag = "R4/R10"; end
      if (op == 8'hDE) begin it.exp = pack(1, 3'd4, 0, 0, 0, 0, 1); it.tag = "R5/R10"; end
    end else if (md == 2'b11) begin
      if (op == 8'hD8 && mr >= 8'hE0 && mr <= 8'hE7) begin
        it.exp = pack(1, 3'd1, 0, i, 0, 0, 0); it.tag = "R6";
      end
      if (op == 8'hDC && mr >= 8'hE8 && mr <= 8'hEF) begin
        it.exp = pack(1, 3'd1, i, 0, 1, 0, 0); it.tag = "R7";
      end
      if (op == 8'hDE && mr >= 8'hE8 && mr <= 8'hEF) begin
        it.exp = pack(1, 3'd1, i, 0, 1, 1, 0); it.tag = (mr == 8'hE9) ? "R9" : "R8";
      end
    end
    return it;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] mr);
    @(posedge clk);
    #1;
    op_byte = op;
    modrm_byte = mr;
    sb_q.push_back(model(op, mr));
  endtask

  // monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [13:0] act;
      it = sb_q.pop_front();
      act = {is_sub, not_family, src_kind, dst_idx, src_idx, reversed, pop_after, int_convert};
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s op=%h modrm=%h actual=%b expected=%b", it.tag, it.op, it.mr, act, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0;
    op_byte = 8'h00;
    modrm_byte = 8'h00;
    repeat (3) @(posedge clk);
    // reset state: idle inputs decode as outside the group (R1)
    @(negedge clk);
    n_run++;
    if (!(not_family === 1'b1 && is_sub === 1'b0)) begin
      n_fail++;
      $display("FAIL R1 reset actual=%b%b expected=01", is_sub, not_family);
    end
    rst_n = 1'b1;
    // directed cases
    drive(8'hD8, 8'h20);  // R2 mod 00
    drive(8'hD8, 8'hA7);  // R2 mod 10, rm 7 (R10)
    drive(8'hDC, 8'h65);  // R3 mod 01
    drive(8'hDA, 8'h26);  // R4
    drive(8'hDE, 8'hA1);  // R5
    drive(8'hD8, 8'hE5);  // R6 i=5
    drive(8'hDC, 8'hEF);  // R7 i=7
    drive(8'hDE, 8'hEB);  // R8 i=3
    drive(8'hDE, 8'hE9);  // R9
    drive(8'hD8, 8'hEA);  // R11 wrong reg
    drive(8'hDC, 8'hE2);  // R11
    drive(8'hDE, 8'hE0);  // R11
    drive(8'hDA, 8'hE1);  // R11 DA mod 11
    drive(8'hD8, 8'h28);  // R1 memory reg 5
    drive(8'hD9, 8'h20);  // R1 other primary
    // full sweep of all byte pairs
    for (int o = 0; o < 256; o++) begin
      for (int m = 0; m < 256; m++) begin
        drive(o[7:0], m[7:0]);
      end
    end
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule